// File: doc/BRIEF.md
# ECC Error-Logging Register File

This block is the software-facing register file of an ECC-protected memory controller. A processor reaches it over a single-beat AXI4-Lite slave port and uses it to switch error correction on or off, enable the error interrupt, read and reset a counter of corrected errors, and inspect what the controller saw when things went wrong.

On the controller side, the block takes a correctable-error pulse and an uncorrectable-error pulse, together with a shared bus that carries the failing data word, its check bits and its address. The first error of each class freezes a snapshot of that bus in its own capture bank. The snapshot stays unchanged until software acknowledges the matching status bit by writing 1 to it. One active-high interrupt line is raised while any status bit is set and its enable bit is set.

Top module: `ecc_logreg`

## Requirements
- R1: After reset the status, interrupt-enable and error-count registers and both capture banks read 0, the interrupt is low, and the ECC on/off register holds the `ONOFF_RST` parameter.
- R2: A write completes only after both its address and its data beats have been accepted, in either order, and neither beat has to come first. Every write and read response is OKAY (2'b00). A pending read response keeps `s_rvalid` high and `s_rdata` stable until `s_rready` is seen.
- R3: Control registers are decoded from address bits [9:2]. Offset 0x04 holds the interrupt enables in bits [1:0], 0x08 holds the ECC on/off flag in bit 0, and 0x0C holds the count in bits [CNT_W-1:0]. Unimplemented bits read 0. Byte lanes whose `s_wstrb` bit is 0 are not written.
- R4: Status at 0x00 has bit 0 for an uncorrectable error and bit 1 for a correctable error. An error pulse sets its bit. Writing 1 to a bit clears it, and writing 0 leaves it unchanged.
- R5: `irq` equals the OR over both status bits of the status bit ANDed with the enable bit at the same position.
- R6: The count rises by one on each correctable-error pulse, does not change on uncorrectable errors, stops at 2^CNT_W-1, and can be overwritten by software.
- R7: The correctable bank captures data, check bits and address only on a pulse while status bit 1 is clear, and holds them while that bit is set. Data is at 0x100 (bits 31:0) upward in 4-byte steps, check bits are at 0x180, the low address word is at 0x1C0, and the high address word is at 0x1C4 only when ADDR_W > 32.
- R8: The uncorrectable bank captures data and check bits only on a pulse while status bit 0 is clear, and holds them while that bit is set. Data is at 0x200 upward in 4-byte steps, and check bits are at 0x280.
- R9: Reads of any offset without a register return 0xDEADDEAD. This includes data words above DATA_W and the high address word when ADDR_W <= 32.
- R10: Writes to the capture registers or to unmapped offsets change no register.
- R11: The `ecc_on` output follows bit 0 of the ECC on/off register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| s_awaddr | input | 10 | Write address |
| s_awvalid | input | 1 | Write address valid |
| s_awready | output | 1 | Write address ready |
| s_wdata | input | 32 | Write data |
| s_wstrb | input | 4 | Write byte strobes |
| s_wvalid | input | 1 | Write data valid |
| s_wready | output | 1 | Write data ready |
| s_bresp | output | 2 | Write response, always OKAY |
| s_bvalid | output | 1 | Write response valid |
| s_bready | input | 1 | Write response ready |
| s_araddr | input | 10 | Read address |
| s_arvalid | input | 1 | Read address valid |
| s_arready | output | 1 | Read address ready |
| s_rdata | output | 32 | Read data |
| s_rresp | output | 2 | Read response, always OKAY |
| s_rvalid | output | 1 | Read data valid |
| s_rready | input | 1 | Read data ready |
| cor_err | input | 1 | Correctable-error pulse |
| unc_err | input | 1 | Uncorrectable-error pulse |
| err_data | input | DATA_W | Failing data word |
| err_ecc | input | ECC_W | Failing check bits |
| err_addr | input | ADDR_W | Failing address |
| ecc_on | output | 1 | ECC enable toward the controller |
| irq | output | 1 | Interrupt, active high |

## Verification
The error path is driven with three patterns: a first error, a second error of the same class while its status bit is still set, and an error of the other class. Together they show whether a bank latched data at the right moment, whether it stayed frozen, and whether the two banks and the counter are kept apart. The register path is driven with writes that present the address first or the data first, with partial strobes, with writes to read-only and unmapped offsets, and with a stalled read. These separate correct handshaking and lane masking from updates that leak through. The enable pattern is changed while status is held, to show that the interrupt depends on each status-enable pair and not on status alone. A run of pulses from just below the counter's maximum checks saturation.

// File: rtl/ecc_logreg_pkg.sv
package ecc_logreg_pkg;

  localparam int REG_AW = 10;

  localparam logic [31:0] RSVD_WORD = 32'hDEAD_DEAD;

  localparam logic [7:0] IDX_STAT  = 8'h00;
  localparam logic [7:0] IDX_IEN   = 8'h01;
  localparam logic [7:0] IDX_ONOFF = 8'h02;
  localparam logic [7:0] IDX_CNT   = 8'h03;
  localparam logic [7:0] IDX_CDATA = 8'h40;
  localparam logic [7:0] IDX_CECC  = 8'h60;
  localparam logic [7:0] IDX_CADDR = 8'h70;
  localparam logic [7:0] IDX_UDATA = 8'h80;
  localparam logic [7:0] IDX_UECC  = 8'hA0;

  localparam int ST_UNC = 0;
  localparam int ST_COR = 1;

  function automatic logic [31:0] strb_mask(input logic [3:0] strb);
    logic [31:0] m;
    for (int i = 0; i < 4; i++) m[8*i +: 8] = {8{strb[i]}};
    return m;
  endfunction

endpackage

// File: rtl/ecc_logreg_axil.sv
module ecc_logreg_axil
  import ecc_logreg_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic [REG_AW-1:0] awaddr,
  input  logic              awvalid,
  output logic              awready,
  input  logic [31:0]       wdata,
  input  logic [3:0]        wstrb,
  input  logic              wvalid,
  output logic              wready,
  output logic              bvalid,
  input  logic              bready,
  input  logic [REG_AW-1:0] araddr,
  input  logic              arvalid,
  output logic              arready,
  output logic [31:0]       rdata,
  output logic              rvalid,
  input  logic              rready,
  output logic              wr_en,
  output logic [7:0]        wr_idx,
  output logic [31:0]       wr_data,
  output logic [3:0]        wr_strb,
  output logic [7:0]        rd_idx,
  input  logic [31:0]       rd_value
);

  logic        aw_held_q, aw_held_d;
  logic [7:0]  aw_idx_q;
  logic        w_held_q, w_held_d;
  logic [31:0] wdata_q;
  logic [3:0]  wstrb_q;
  logic        bvalid_q, bvalid_d;
  logic        rvalid_q, rvalid_d;
  logic [31:0] rdata_q;
  logic        aw_take, w_take, rd_take;
  logic        unused_lsb;

  assign unused_lsb = ^{awaddr[1:0], araddr[1:0]};

  assign awready = ~aw_held_q;
  assign wready  = ~w_held_q;
  assign arready = ~rvalid_q;
  assign aw_take = awvalid & awready;
  assign w_take  = wvalid & wready;
  assign rd_take = arvalid & arready;

  assign wr_en   = aw_held_q & w_held_q & ~bvalid_q;
  assign wr_idx  = aw_idx_q;
  assign wr_data = wdata_q;
  assign wr_strb = wstrb_q;
  assign rd_idx  = araddr[9:2];

  assign bvalid  = bvalid_q;
  assign rvalid  = rvalid_q;
  assign rdata   = rdata_q;

  always_comb begin
    aw_held_d = (aw_held_q & ~wr_en) | aw_take;
    w_held_d  = (w_held_q & ~wr_en) | w_take;
    bvalid_d  = wr_en | (bvalid_q & ~bready);
    rvalid_d  = rd_take | (rvalid_q & ~rready);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      aw_held_q <= 1'b0;
      w_held_q  <= 1'b0;
      bvalid_q  <= 1'b0;
      rvalid_q  <= 1'b0;
    end else begin
      aw_held_q <= aw_held_d;
      w_held_q  <= w_held_d;
      bvalid_q  <= bvalid_d;
      rvalid_q  <= rvalid_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      aw_idx_q <= '0;
      wdata_q  <= '0;
      wstrb_q  <= '0;
      rdata_q  <= '0;
    end else begin
      if (aw_take) aw_idx_q <= awaddr[9:2];
      if (w_take) begin
        wdata_q <= wdata;
        wstrb_q <= wstrb;
      end
      if (rd_take) rdata_q <= rd_value;
    end
  end

  // R2: write response is held until accepted
  p_bvalid_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (bvalid_q && !bready) |=> bvalid_q);

  // R2: read data stays valid and unchanged while stalled
  p_rvalid_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (rvalid_q && !rready) |=> (rvalid_q && $stable(rdata_q)));

  // R2: a response only appears after both beats were held
  p_resp_needs_both_r2: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(bvalid_q) |-> ($past(aw_held_q) && $past(w_held_q)));

endmodule

// File: rtl/ecc_logreg_ctrl.sv
module ecc_logreg_ctrl
  import ecc_logreg_pkg::*;
#(
  parameter int CNT_W     = 8,
  parameter bit ONOFF_RST = 1'b0
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_en,
  input  logic [7:0]       wr_idx,
  input  logic [31:0]      wr_data,
  input  logic [3:0]       wr_strb,
  input  logic             cor_pulse,
  input  logic             unc_pulse,
  output logic [1:0]       status,
  output logic [1:0]       irq_en,
  output logic             onoff,
  output logic [CNT_W-1:0] cnt,
  output logic             irq
);

  localparam logic [CNT_W-1:0] CNT_MAX = '1;
  localparam logic [CNT_W-1:0] CNT_ONE = CNT_W'(1);

  logic [1:0]       status_q, status_d;
  logic [1:0]       ien_q, ien_d;
  logic             onoff_q, onoff_d;
  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic [31:0]      bmask;
  logic             wr_stat, wr_ien, wr_onoff, wr_cnt;
  logic             status_ce, ien_ce, onoff_ce, cnt_ce;
  logic             unused_bits;

  assign bmask    = strb_mask(wr_strb);
  assign wr_stat  = wr_en && (wr_idx == IDX_STAT);
  assign wr_ien   = wr_en && (wr_idx == IDX_IEN);
  assign wr_onoff = wr_en && (wr_idx == IDX_ONOFF);
  assign wr_cnt   = wr_en && (wr_idx == IDX_CNT);
  assign unused_bits = ^{wr_data, bmask};

  assign status_ce = wr_stat | cor_pulse | unc_pulse;
  assign ien_ce    = wr_ien;
  assign onoff_ce  = wr_onoff & bmask[0];
  assign cnt_ce    = wr_cnt | (cor_pulse & (cnt_q != CNT_MAX));

  always_comb begin
    status_d = status_q;
    if (wr_stat) status_d = status_q & ~(wr_data[1:0] & bmask[1:0]);
    status_d = status_d | {cor_pulse, unc_pulse};

    ien_d   = (wr_data[1:0] & bmask[1:0]) | (ien_q & ~bmask[1:0]);
    onoff_d = wr_data[0];

    if (wr_cnt)
      cnt_d = (wr_data[CNT_W-1:0] & bmask[CNT_W-1:0]) | (cnt_q & ~bmask[CNT_W-1:0]);
    else
      cnt_d = cnt_q + CNT_ONE;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      status_q <= '0;
      ien_q    <= '0;
      onoff_q  <= ONOFF_RST;
      cnt_q    <= '0;
    end else begin
      if (status_ce) status_q <= status_d;
      if (ien_ce)    ien_q    <= ien_d;
      if (onoff_ce)  onoff_q  <= onoff_d;
      if (cnt_ce)    cnt_q    <= cnt_d;
    end
  end

  assign status = status_q;
  assign irq_en = ien_q;
  assign onoff  = onoff_q;
  assign cnt    = cnt_q;
  assign irq    = |(status_q & ien_q);

  // R6: count holds at its maximum
  p_cnt_saturate_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (cnt_q == CNT_MAX && !wr_cnt) |=> (cnt_q == CNT_MAX));

  // R6: one step per correctable error below the maximum
  p_cnt_step_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (cor_pulse && cnt_q != CNT_MAX && !wr_cnt) |=> (cnt_q == $past(cnt_q) + CNT_ONE));

  // R4: correctable status stays set until software writes to status
  p_status_sticky_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (status_q[ST_COR] && !wr_stat) |=> status_q[ST_COR]);

  // R5: an enabled error raises the interrupt on the next cycle
  p_irq_on_error_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (unc_pulse && ien_q[ST_UNC] && !wr_ien) |=> irq);

endmodule

// File: rtl/ecc_logreg_capture.sv
module ecc_logreg_capture #(
  parameter int W = 72
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         frozen,
  input  logic         pulse,
  input  logic [W-1:0] din,
  output logic [W-1:0] q
);

  logic [W-1:0] q_q, q_d;
  logic         take;

  assign take = pulse & ~frozen;

  always_comb begin
    q_d = din;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) q_q <= '0;
    else if (take) q_q <= q_d;
  end

  assign q = q_q;

  // R7 and R8: a bank stays frozen while its status bit is set
  p_frozen_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
    frozen |=> $stable(q_q));

  // R7 and R8: the first error of the class lands in the bank
  p_first_capture_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (pulse && !frozen) |=> (q_q == $past(din)));

endmodule

// File: rtl/ecc_logreg.sv
module ecc_logreg
  import ecc_logreg_pkg::*;
#(
  parameter int DATA_W    = 64,
  parameter int ECC_W     = 8,
  parameter int ADDR_W    = 32,
  parameter int CNT_W     = 8,
  parameter bit ONOFF_RST = 1'b0
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [REG_AW-1:0] s_awaddr,
  input  logic              s_awvalid,
  output logic              s_awready,
  input  logic [31:0]       s_wdata,
  input  logic [3:0]        s_wstrb,
  input  logic              s_wvalid,
  output logic              s_wready,
  output logic [1:0]        s_bresp,
  output logic              s_bvalid,
  input  logic              s_bready,
  input  logic [REG_AW-1:0] s_araddr,
  input  logic              s_arvalid,
  output logic              s_arready,
  output logic [31:0]       s_rdata,
  output logic [1:0]        s_rresp,
  output logic              s_rvalid,
  input  logic              s_rready,
  input  logic              cor_err,
  input  logic              unc_err,
  input  logic [DATA_W-1:0] err_data,
  input  logic [ECC_W-1:0]  err_ecc,
  input  logic [ADDR_W-1:0] err_addr,
  output logic              ecc_on,
  output logic              irq
);

  localparam int DW_WORDS = DATA_W / 32;
  localparam bit ADDR_HI  = (ADDR_W > 32);
  localparam int COR_W    = DATA_W + ECC_W + ADDR_W;
  localparam int UNC_W    = DATA_W + ECC_W;

  logic              wr_en;
  logic [7:0]        wr_idx;
  logic [31:0]       wr_data;
  logic [3:0]        wr_strb;
  logic [7:0]        rd_idx;
  logic [31:0]       rd_value;
  logic [1:0]        status, irq_en;
  logic              onoff;
  logic [CNT_W-1:0]  cnt;
  logic [COR_W-1:0]  cor_q;
  logic [UNC_W-1:0]  unc_q;
  logic [DATA_W-1:0] cor_data, unc_data;
  logic [ECC_W-1:0]  cor_ecc, unc_ecc;
  logic [ADDR_W-1:0] cor_addr;
  logic [31:0]       addr_lo, addr_hi;

  ecc_logreg_axil u_axil (
    .clk      (clk),
    .rst_n    (rst_n),
    .awaddr   (s_awaddr),
    .awvalid  (s_awvalid),
    .awready  (s_awready),
    .wdata    (s_wdata),
    .wstrb    (s_wstrb),
    .wvalid   (s_wvalid),
    .wready   (s_wready),
    .bvalid   (s_bvalid),
    .bready   (s_bready),
    .araddr   (s_araddr),
    .arvalid  (s_arvalid),
    .arready  (s_arready),
    .rdata    (s_rdata),
    .rvalid   (s_rvalid),
    .rready   (s_rready),
    .wr_en    (wr_en),
    .wr_idx   (wr_idx),
    .wr_data  (wr_data),
    .wr_strb  (wr_strb),
    .rd_idx   (rd_idx),
    .rd_value (rd_value)
  );

  assign s_bresp = 2'b00;
  assign s_rresp = 2'b00;

  ecc_logreg_ctrl #(
    .CNT_W     (CNT_W),
    .ONOFF_RST (ONOFF_RST)
  ) u_ctrl (
    .clk       (clk),
    .rst_n     (rst_n),
    .wr_en     (wr_en),
    .wr_idx    (wr_idx),
    .wr_data   (wr_data),
    .wr_strb   (wr_strb),
    .cor_pulse (cor_err),
    .unc_pulse (unc_err),
    .status    (status),
    .irq_en    (irq_en),
    .onoff     (onoff),
    .cnt       (cnt),
    .irq       (irq)
  );

  assign ecc_on = onoff;

  ecc_logreg_capture #(.W(COR_W)) u_cor_bank (
    .clk    (clk),
    .rst_n  (rst_n),
    .frozen (status[ST_COR]),
    .pulse  (cor_err),
    .din    ({err_addr, err_ecc, err_data}),
    .q      (cor_q)
  );

  ecc_logreg_capture #(.W(UNC_W)) u_unc_bank (
    .clk    (clk),
    .rst_n  (rst_n),
    .frozen (status[ST_UNC]),
    .pulse  (unc_err),
    .din    ({err_ecc, err_data}),
    .q      (unc_q)
  );

  assign {cor_addr, cor_ecc, cor_data} = cor_q;
  assign {unc_ecc, unc_data}           = unc_q;

  generate
    if (ADDR_HI) begin : g_addr_wide
      assign addr_lo = cor_addr[31:0];
      assign addr_hi = 32'(cor_addr[ADDR_W-1:32]);
    end else begin : g_addr_narrow
      assign addr_lo = 32'(cor_addr);
      assign addr_hi = '0;
    end
  endgenerate

  always_comb begin
    rd_value = RSVD_WORD;
    unique case (rd_idx)
      IDX_STAT:  rd_value = 32'(status);
      IDX_IEN:   rd_value = 32'(irq_en);
      IDX_ONOFF: rd_value = 32'(onoff);
      IDX_CNT:   rd_value = 32'(cnt);
      IDX_CECC:  rd_value = 32'(cor_ecc);
      IDX_UECC:  rd_value = 32'(unc_ecc);
      IDX_CADDR: rd_value = addr_lo;
      default:   rd_value = RSVD_WORD;
    endcase
    if (ADDR_HI && rd_idx == IDX_CADDR + 8'd1) rd_value = addr_hi;
    for (int k = 0; k < DW_WORDS; k++) begin
      if (rd_idx == IDX_CDATA + 8'(k)) rd_value = cor_data[32*k +: 32];
      if (rd_idx == IDX_UDATA + 8'(k)) rd_value = unc_data[32*k +: 32];
    end
  end

  // R9: unmapped offsets above the control block read the marker
  p_rsvd_marker_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_idx > IDX_UECC) |-> (rd_value == RSVD_WORD));

endmodule

// File: tb/tb_ecc_logreg.sv
`timescale 1ns/1ps
module tb_ecc_logreg;

  logic        clk = 1'b0;
  logic        rst_n;
  logic [9:0]  awaddr, araddr;
  logic        awvalid, wvalid, bready, arvalid, rready;
  logic        awready, wready, bvalid, arready, rvalid;
  logic [31:0] wdata, rdata;
  logic [3:0]  wstrb;
  logic [1:0]  bresp, rresp;
  logic        cor_err, unc_err;
  logic [63:0] err_data;
  logic [7:0]  err_ecc;
  logic [31:0] err_addr;
  logic        ecc_on, irq;

  int n_chk  = 0;
  int n_fail = 0;

  always #2 clk = ~clk;

  ecc_logreg dut (
    .clk(clk), .rst_n(rst_n),
    .s_awaddr(awaddr), .s_awvalid(awvalid), .s_awready(awready),
    .s_wdata(wdata), .s_wstrb(wstrb), .s_wvalid(wvalid), .s_wready(wready),
    .s_bresp(bresp), .s_bvalid(bvalid), .s_bready(bready),
    .s_araddr(araddr), .s_arvalid(arvalid), .s_arready(arready),
    .s_rdata(rdata), .s_rresp(rresp), .s_rvalid(rvalid), .s_rready(rready),
    .cor_err(cor_err), .unc_err(unc_err),
    .err_data(err_data), .err_ecc(err_ecc), .err_addr(err_addr),
    .ecc_on(ecc_on), .irq(irq)
  );

  typedef struct packed {
    logic        wr;
    logic [9:0]  addr;
    logic [31:0] data;
    logic [3:0]  strb;
    logic [31:0] exp;
    logic [3:0]  req;
  } vec_t;

  localparam int NV = 34;
  localparam vec_t TBL [NV] = '{
    '{1'b0, 10'h000, 32'h0, 4'h0, 32'h0, 4'd1},          // R1 status
    '{1'b0, 10'h004, 32'h0, 4'h0, 32'h0, 4'd1},          // R1 enables
    '{1'b0, 10'h008, 32'h0, 4'h0, 32'h0, 4'd1},          // R1 on/off default
    '{1'b0, 10'h00C, 32'h0, 4'h0, 32'h0, 4'd1},          // R1 count
    '{1'b0, 10'h100, 32'h0, 4'h0, 32'h0, 4'd1},          // R1 cor data
    '{1'b0, 10'h180, 32'h0, 4'h0, 32'h0, 4'd1},          // R1 cor ecc
    '{1'b0, 10'h1C0, 32'h0, 4'h0, 32'h0, 4'd1},          // R1 cor addr
    '{1'b0, 10'h200, 32'h0, 4'h0, 32'h0, 4'd1},          // R1 unc data
    '{1'b0, 10'h280, 32'h0, 4'h0, 32'h0, 4'd1},          // R1 unc ecc
    '{1'b1, 10'h004, 32'hFFFF_FFFF, 4'hF, 32'h0, 4'd3},
    '{1'b0, 10'h004, 32'h0, 4'h0, 32'h3, 4'd3},          // R3 two enable bits
    '{1'b1, 10'h008, 32'hFFFF_FFFE, 4'hF, 32'h0, 4'd3},
    '{1'b0, 10'h008, 32'h0, 4'h0, 32'h0, 4'd3},          // R3 only bit 0
    '{1'b1, 10'h008, 32'h0000_0001, 4'hF, 32'h0, 4'd3},
    '{1'b0, 10'h008, 32'h0, 4'h0, 32'h1, 4'd3},          // R3 on/off set
    '{1'b1, 10'h00C, 32'h1234_5605, 4'hF, 32'h0, 4'd3},
    '{1'b0, 10'h00C, 32'h0, 4'h0, 32'h5, 4'd3},          // R3 count width
    '{1'b1, 10'h00C, 32'h0000_00FF, 4'h2, 32'h0, 4'd3},
    '{1'b0, 10'h00C, 32'h0, 4'h0, 32'h5, 4'd3},          // R3 strobe masks lane 0
    '{1'b0, 10'h010, 32'h0, 4'h0, 32'hDEAD_DEAD, 4'd9},  // R9 gap
    '{1'b0, 10'h108, 32'h0, 4'h0, 32'hDEAD_DEAD, 4'd9},  // R9 data above DATA_W
    '{1'b0, 10'h10C, 32'h0, 4'h0, 32'hDEAD_DEAD, 4'd9},  // R9
    '{1'b0, 10'h1C4, 32'h0, 4'h0, 32'hDEAD_DEAD, 4'd9},  // R9 narrow address
    '{1'b0, 10'h284, 32'h0, 4'h0, 32'hDEAD_DEAD, 4'd9},  // R9
    '{1'b0, 10'h3FC, 32'h0, 4'h0, 32'hDEAD_DEAD, 4'd9},  // R9 top of map
    '{1'b1, 10'h100, 32'hFFFF_FFFF, 4'hF, 32'h0, 4'd10},
    '{1'b0, 10'h100, 32'h0, 4'h0, 32'h0, 4'd10},         // R10 capture is read-only
    '{1'b1, 10'h180, 32'hFFFF_FFFF, 4'hF, 32'h0, 4'd10},
    '{1'b0, 10'h180, 32'h0, 4'h0, 32'h0, 4'd10},         // R10
    '{1'b1, 10'h010, 32'hFFFF_FFFF, 4'hF, 32'h0, 4'd10},
    '{1'b0, 10'h004, 32'h0, 4'h0, 32'h3, 4'd10},         // R10 unmapped write
    '{1'b0, 10'h00C, 32'h0, 4'h0, 32'h5, 4'd10},         // R10
    '{1'b0, 10'h000, 32'h0, 4'h0, 32'h0, 4'd10},         // R10
    '{1'b0, 10'h008, 32'h0, 4'h0, 32'h1, 4'd10}          // R10
  };

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual 0x%08h expected 0x%08h", tag, act, exp);
    end
  endtask

  task automatic axi_wr(input logic [9:0] a, input logic [31:0] d, input logic [3:0] s,
                        input int aw_dly, input int w_dly);
    int  c = 0;
    bit  ad = 0, wd = 0, early = 0;
    logic a_hs, w_hs;
    @(negedge clk);
    while (!(ad && wd)) begin
      if (c == aw_dly) begin awvalid = 1'b1; awaddr = a; end
      if (c == w_dly)  begin wvalid = 1'b1; wdata = d; wstrb = s; end
      a_hs = awvalid && awready;
      w_hs = wvalid && wready;
      if (bvalid) early = 1;
      @(negedge clk);
      c++;
      if (a_hs) begin awvalid = 1'b0; ad = 1; end
      if (w_hs) begin wvalid = 1'b0; wd = 1; end
    end
    chk("R2 no response before both beats", {31'd0, early}, 32'd0);
    while (!bvalid) @(negedge clk);
    chk("R2 bresp OKAY", {30'd0, bresp}, 32'd0);
    @(negedge clk);
  endtask

  task automatic axi_rd(input logic [9:0] a, output logic [31:0] d, input int stall);
    logic [31:0] first;
    @(negedge clk);
    arvalid = 1'b1;
    araddr  = a;
    rready  = (stall == 0);
    while (!arready) @(negedge clk);
    @(negedge clk);
    arvalid = 1'b0;
    while (!rvalid) @(negedge clk);
    first = rdata;
    for (int i = 0; i < stall; i++) begin
      @(negedge clk);
      chk("R2 rvalid held while stalled", {31'd0, rvalid}, 32'd1);
      chk("R2 rdata stable while stalled", rdata, first);
    end
    rready = 1'b1;
    d = rdata;
    chk("R2 rresp OKAY", {30'd0, rresp}, 32'd0);
    @(negedge clk);
  endtask

  task automatic rd_chk(input string tag, input logic [9:0] a, input logic [31:0] exp);
    logic [31:0] v;
    axi_rd(a, v, 0);
    chk(tag, v, exp);
  endtask

  task automatic pulse(input bit cor, input logic [63:0] d, input logic [7:0] e,
                       input logic [31:0] ad);
    @(negedge clk);
    err_data = d; err_ecc = e; err_addr = ad;
    cor_err = cor; unc_err = ~cor;
    @(negedge clk);
    cor_err = 1'b0; unc_err = 1'b0;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    logic [31:0] v;
    rst_n = 1'b0;
    awaddr = '0; araddr = '0; awvalid = 0; wvalid = 0; arvalid = 0;
    wdata = '0; wstrb = '0; bready = 1'b1; rready = 1'b1;
    cor_err = 0; unc_err = 0; err_data = '0; err_ecc = '0; err_addr = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    chk("R1 irq low after reset", {31'd0, irq}, 32'd0);
    chk("R1 ecc_on equals reset parameter", {31'd0, ecc_on}, 32'd0);
    chk("R1 no response pending", {30'd0, bvalid, rvalid}, 32'd0);

    for (int i = 0; i < NV; i++) begin
      if (TBL[i].wr)
        axi_wr(TBL[i].addr, TBL[i].data, TBL[i].strb, 0, 0);
      else begin
        axi_rd(TBL[i].addr, v, 0);
        chk($sformatf("R%0d table row %0d", TBL[i].req, i), v, TBL[i].exp);
      end
    end

    chk("R11 ecc_on follows register", {31'd0, ecc_on}, 32'd1);
    axi_wr(10'h008, 32'h0, 4'hF, 0, 0);
    chk("R11 ecc_on cleared", {31'd0, ecc_on}, 32'd0);
    axi_wr(10'h008, 32'h1, 4'hF, 0, 0);

    // R2: data beat first, then address
    axi_wr(10'h004, 32'h0, 4'hF, 3, 0);
    rd_chk("R2 data-first write landed", 10'h004, 32'h0);
    // R2: address beat first, then data
    axi_wr(10'h004, 32'h3, 4'hF, 0, 2);
    rd_chk("R2 address-first write landed", 10'h004, 32'h3);

    // R7: first correctable error
    pulse(1'b1, 64'h0123_4567_89AB_CDEF, 8'h5A, 32'hCAFE_0040);
    chk("R5 irq after enabled correctable error", {31'd0, irq}, 32'd1);
    rd_chk("R4 correctable bit set", 10'h000, 32'h2);
    rd_chk("R7 cor data low", 10'h100, 32'h89AB_CDEF);
    rd_chk("R7 cor data high", 10'h104, 32'h0123_4567);
    rd_chk("R7 cor ecc", 10'h180, 32'h5A);
    rd_chk("R7 cor addr", 10'h1C0, 32'hCAFE_0040);
    rd_chk("R6 count after one error", 10'h00C, 32'h6);

    // R7: second correctable error must not overwrite
    pulse(1'b1, 64'hFFFF_0000_FFFF_0000, 8'h11, 32'h0000_0BAD);
    rd_chk("R7 cor data frozen", 10'h100, 32'h89AB_CDEF);
    rd_chk("R7 cor ecc frozen", 10'h180, 32'h5A);
    rd_chk("R7 cor addr frozen", 10'h1C0, 32'hCAFE_0040);
    rd_chk("R6 count after two errors", 10'h00C, 32'h7);

    // R4: write-one-to-clear
    axi_wr(10'h000, 32'h1, 4'hF, 0, 0);
    rd_chk("R4 writing 0 to bit 1 keeps it", 10'h000, 32'h2);
    axi_wr(10'h000, 32'h2, 4'hF, 0, 0);
    rd_chk("R4 writing 1 clears bit 1", 10'h000, 32'h0);
    chk("R5 irq low with status clear", {31'd0, irq}, 32'd0);

    // R8: uncorrectable error
    pulse(1'b0, 64'hFEDC_BA98_7654_3210, 8'hC3, 32'h0);
    chk("R5 irq after enabled uncorrectable error", {31'd0, irq}, 32'd1);
    rd_chk("R4 uncorrectable bit set", 10'h000, 32'h1);
    rd_chk("R8 unc data low", 10'h200, 32'h7654_3210);
    rd_chk("R8 unc data high", 10'h204, 32'hFEDC_BA98);
    rd_chk("R8 unc ecc", 10'h280, 32'hC3);
    rd_chk("R6 count ignores uncorrectable", 10'h00C, 32'h7);
    rd_chk("R7 cor bank untouched by other class", 10'h100, 32'h89AB_CDEF);

    pulse(1'b0, 64'h1111_2222_3333_4444, 8'h77, 32'h0);
    rd_chk("R8 unc data frozen", 10'h200, 32'h7654_3210);
    rd_chk("R8 unc ecc frozen", 10'h280, 32'hC3);

    // R10: write to capture bank has no effect
    axi_wr(10'h204, 32'h0, 4'hF, 0, 0);
    rd_chk("R10 unc bank not writable", 10'h204, 32'hFEDC_BA98);

    // R5: interrupt needs a matching enable
    axi_wr(10'h004, 32'h2, 4'hF, 0, 0);
    chk("R5 irq low when only other class enabled", {31'd0, irq}, 32'd0);
    axi_wr(10'h004, 32'h1, 4'hF, 0, 0);
    chk("R5 irq high with matching enable", {31'd0, irq}, 32'd1);

    // R6: saturation
    axi_wr(10'h00C, 32'hFD, 4'hF, 0, 0);
    rd_chk("R6 count overwritten", 10'h00C, 32'hFD);
    for (int i = 0; i < 4; i++) pulse(1'b1, 64'h0, 8'h0, 32'h0);
    rd_chk("R6 count saturates", 10'h00C, 32'hFF);

    // R2: stalled read
    axi_rd(10'h180, v, 3);
    chk("R2 stalled read data", v, 32'h0);

    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

endmodule